// File: doc/BRIEF.md
# Status Channel Sync Tracker

This block watches a received two-bit status stream and decides whether the link partner's status framing can be trusted. Each status pass starts with a framing word `11`. In two-calendar mode a calendar selection word comes next. Then come `CAL_LEN` status words, and a DIP-2 parity word closes the pass. The block checks every completed pass and keeps a run of good or bad passes. The result is a single sync flag with two values: out of sync or in sync.

Consecutive good passes bring the flag up, and the number needed is set by configuration. Consecutive bad passes bring it down, again by a configured count. A run of all-ones training words or a disabled port also clears the flag. Each change of the flag can raise a one-cycle interrupt pulse.

The status input is a valid-qualified stream with no ready signal. The receiver can never apply back-pressure, so a word is consumed on every clock edge where `stat_valid` is high. Cycles with `stat_valid` low are skipped entirely, whatever `stat_word` carries. Configuration and interrupt pins are plain levels.

Top module: `stsync_top`

## Requirements
- R1: While `rst_n` is low, and after it rises, `sync_valid` is 0 and `irq` is 0.
- R2: While out of sync, the flag rises at the clock edge that accepts the DIP word of the N-th consecutive good pass, where N is `good_thresh`. A `good_thresh` of 0 acts as 1. A bad pass restarts the count.
- R3: While in sync, the flag falls at the edge that accepts the DIP word of the M-th consecutive bad pass, where M is `bad_thresh`. A `bad_thresh` of 0 acts as 1. A good pass restarts the count.
- R4: The 12th consecutive accepted `11` word drops the flag at the edge that accepts it, whatever the parser phase. Eleven such words do not drop it on their own.
- R5: When `port_en` is low, the flag is 0 after the next edge and the parser returns to hunting. Passes sent while `port_en` is low have no effect.
- R6: `irq` is high for exactly the one cycle after each change of `sync_valid`, and only if `irq_en` was high at the edge of the change. Otherwise `irq` is 0.
- R7: With `dual_cal_en` high, the word after the framing word must be `01` when `cal_sel` is 0 and `10` when `cal_sel` is 1. Any other value makes the pass bad, even when its parity is correct.
- R8: A pass is: framing `11`, then the selection word (dual mode only), then `CAL_LEN` words, then the DIP word. Non-`11` words are skipped while hunting. The parity accumulator starts at 00. For each word w after the framing word, including the selection word, the accumulator becomes {acc[0],acc[1]} XOR w. The pass is good when the DIP word equals the bitwise inverse of one further step with w = `11`. Words are taken only when `stat_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_valid | input | 1 | A status word is present this cycle |
| stat_word | input | 2 | Received status word |
| port_en | input | 1 | Port enabled; low forces out of sync |
| dual_cal_en | input | 1 | Expect a calendar selection word |
| cal_sel | input | 1 | Configured calendar, 0 or 1 |
| good_thresh | input | THR_W | Good passes needed to gain sync |
| bad_thresh | input | THR_W | Bad passes needed to lose sync |
| irq_en | input | 1 | Enable the change interrupt |
| sync_valid | output | 1 | 1 = in sync |
| irq | output | 1 | One-cycle pulse on a sync change |

## Verification
The hardest case to reach is the exact twelve-word boundary of the training run. The framing parser consumes `11` words as framing, data and DIP words, so it completes and judges a pass partway through the run. That judgement could move the flag before the run length does. The stimulus first raises `bad_thresh` to its maximum and sends one `00` word, which clears any partial run. It then sends eleven `11` words and checks that sync holds, and sends a twelfth and checks that sync drops. The threshold sweeps cover every value from 0 to 4 for gaining sync and from 1 to 3 for losing it.

// File: rtl/stsync_pkg.sv
package stsync_pkg;

  localparam int TRAIN_RUN = 12;

  typedef enum logic [1:0] {
    PH_HUNT,
    PH_SEL,
    PH_DATA,
    PH_DIP
  } phase_e;

  typedef enum logic {
    ST_OOS,
    ST_INSYNC
  } sync_e;

  // one step of the diagonal parity: rotate the pair, then fold in the word
  function automatic logic [1:0] dip_step(input logic [1:0] acc, input logic [1:0] w);
    return {acc[0], acc[1]} ^ w;
  endfunction

endpackage

// File: rtl/stsync_framer.sv
module stsync_framer
  import stsync_pkg::*;
#(
  parameter int CAL_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       valid,
  input  logic [1:0] word,
  input  logic       dual_en,
  input  logic       cal_sel,
  output logic       pass_done,
  output logic       pass_good,
  output logic       train_hit
);

  localparam int IW = (CAL_LEN > 1) ? $clog2(CAL_LEN) : 1;
  localparam int RW = $clog2(TRAIN_RUN + 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(CAL_LEN - 1);
  localparam logic [RW-1:0] RUN_MAX  = RW'(TRAIN_RUN);
  localparam logic [RW-1:0] RUN_LAST = RW'(TRAIN_RUN - 1);

  phase_e        phase;
  logic [1:0]    acc;
  logic [IW-1:0] idx;
  logic [RW-1:0] run;
  logic          sel_bad;
  logic [1:0]    sel_exp;
  logic [1:0]    dip_exp;
  logic          is_ones;

  assign is_ones   = (word == 2'b11);
  assign sel_exp   = cal_sel ? 2'b10 : 2'b01;
  assign dip_exp   = ~dip_step(acc, 2'b11);
  assign train_hit = valid && !clr && is_ones && (run >= RUN_LAST);
  assign pass_done = valid && !clr && (phase == PH_DIP) && !train_hit;
  assign pass_good = (word == dip_exp) && !sel_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_HUNT;
      acc     <= 2'b00;
      idx     <= '0;
      run     <= '0;
      sel_bad <= 1'b0;
    end else if (clr) begin
      phase   <= PH_HUNT;
      acc     <= 2'b00;
      idx     <= '0;
      run     <= '0;
      sel_bad <= 1'b0;
    end else if (valid) begin
      if (is_ones) begin
        run <= (run == RUN_MAX) ? RUN_MAX : run + 1'b1;
      end else begin
        run <= '0;
      end
      if (train_hit) begin
        phase <= PH_HUNT;
      end else begin
        unique case (phase)
          PH_HUNT: begin
            if (is_ones) begin
              acc     <= 2'b00;
              idx     <= '0;
              sel_bad <= 1'b0;
              phase   <= dual_en ? PH_SEL : PH_DATA;
            end
          end
          PH_SEL: begin
            acc     <= dip_step(acc, word);
            sel_bad <= (word != sel_exp);
            phase   <= PH_DATA;
          end
          PH_DATA: begin
            acc <= dip_step(acc, word);
            idx <= idx + 1'b1;
            if (idx == IDX_LAST) phase <= PH_DIP;
          end
          PH_DIP: begin
            phase <= PH_HUNT;
          end
          default: phase <= PH_HUNT;
        endcase
      end
    end
  end

endmodule

// File: rtl/stsync_fsm.sv
module stsync_fsm
  import stsync_pkg::*;
#(
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             pass_done,
  input  logic             pass_good,
  input  logic             train_hit,
  input  logic [THR_W-1:0] good_thresh,
  input  logic [THR_W-1:0] bad_thresh,
  input  logic             irq_en,
  output logic             sync_valid,
  output logic             irq
);

  sync_e          cur, nxt;
  logic [THR_W-1:0] cnt, nxt_cnt;
  logic [THR_W:0]   cnt_inc, g_eff, b_eff;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign g_eff   = (good_thresh == '0) ? (THR_W+1)'(1) : {1'b0, good_thresh};
  assign b_eff   = (bad_thresh == '0) ? (THR_W+1)'(1) : {1'b0, bad_thresh};

  always_comb begin
    nxt     = cur;
    nxt_cnt = cnt;
    if (!port_en || train_hit) begin
      nxt     = ST_OOS;
      nxt_cnt = '0;
    end else if (pass_done) begin
      if (cur == ST_OOS) begin
        if (pass_good) begin
          if (cnt_inc >= g_eff) begin
            nxt     = ST_INSYNC;
            nxt_cnt = '0;
          end else begin
            nxt_cnt = cnt_inc[THR_W-1:0];
          end
        end else begin
          nxt_cnt = '0;
        end
      end else begin
        if (!pass_good) begin
          if (cnt_inc >= b_eff) begin
            nxt     = ST_OOS;
            nxt_cnt = '0;
          end else begin
            nxt_cnt = cnt_inc[THR_W-1:0];
          end
        end else begin
          nxt_cnt = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= ST_OOS;
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      cur <= nxt;
      cnt <= nxt_cnt;
      irq <= irq_en && (nxt != cur);
    end
  end

  assign sync_valid = (cur == ST_INSYNC);

endmodule

// File: rtl/stsync_top.sv
module stsync_top
  import stsync_pkg::*;
#(
  parameter int CAL_LEN = 4,
  parameter int THR_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_valid,
  input  logic [1:0]       stat_word,
  input  logic             port_en,
  input  logic             dual_cal_en,
  input  logic             cal_sel,
  input  logic [THR_W-1:0] good_thresh,
  input  logic [THR_W-1:0] bad_thresh,
  input  logic             irq_en,
  output logic             sync_valid,
  output logic             irq
);

  logic pass_done, pass_good, train_hit;

  stsync_framer #(.CAL_LEN(CAL_LEN)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!port_en),
    .valid     (stat_valid),
    .word      (stat_word),
    .dual_en   (dual_cal_en),
    .cal_sel   (cal_sel),
    .pass_done (pass_done),
    .pass_good (pass_good),
    .train_hit (train_hit)
  );

  stsync_fsm #(.THR_W(THR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_en     (port_en),
    .pass_done   (pass_done),
    .pass_good   (pass_good),
    .train_hit   (train_hit),
    .good_thresh (good_thresh),
    .bad_thresh  (bad_thresh),
    .irq_en      (irq_en),
    .sync_valid  (sync_valid),
    .irq         (irq)
  );

endmodule

// File: rtl/stsync_chk.sv
module stsync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_valid,
  input logic [1:0] stat_word,
  input logic       port_en,
  input logic       irq_en,
  input logic       sync_valid,
  input logic       irq
);

  logic [3:0] ones_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_run <= '0;
    else if (!port_en) ones_run <= '0;
    else if (stat_valid) begin
      if (stat_word == 2'b11) ones_run <= (ones_run >= 4'd12) ? 4'd12 : ones_run + 4'd1;
      else ones_run <= '0;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> !sync_valid && !irq);

  p_rise_on_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_valid) |-> $past(stat_valid) && $past(port_en));

  p_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_valid) |-> $past(stat_valid) || !$past(port_en));

  p_train_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && stat_valid && stat_word == 2'b11 && ones_run >= 4'd11) |=> !sync_valid);

  p_disable_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !sync_valid);

  p_irq_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_valid != $past(sync_valid)) |-> (irq == $past(irq_en)));

  p_irq_needs_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sync_valid != $past(sync_valid)));

endmodule

bind stsync_top stsync_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stat_valid (stat_valid),
  .stat_word  (stat_word),
  .port_en    (port_en),
  .irq_en     (irq_en),
  .sync_valid (sync_valid),
  .irq        (irq)
);

// File: tb/stsync_top_test.sv
`timescale 1ns/1ps
module stsync_top_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sv = 1'b0;
  logic [1:0] sw = 2'b00;
  logic       port_en = 1'b1;
  logic       dual = 1'b0;
  logic       csel = 1'b0;
  logic [3:0] gth = 4'd3;
  logic [3:0] bth = 4'd2;
  logic       irq_en = 1'b1;
  logic       sync_valid, irq;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  stsync_top #(.CAL_LEN(4), .THR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .stat_valid(sv), .stat_word(sw), .port_en(port_en),
    .dual_cal_en(dual), .cal_sel(csel), .good_thresh(gth), .bad_thresh(bth),
    .irq_en(irq_en), .sync_valid(sync_valid), .irq(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic [1:0] step(input logic [1:0] a, input logic [1:0] w);
    return {a[0], a[1]} ^ w;
  endfunction

  task automatic put(input logic [1:0] w);
    sv = 1'b1; sw = w;
    @(posedge clk); #1;
    sv = 1'b0; sw = 2'b00;
  endtask

  task automatic idle();
    sv = 1'b0; sw = 2'b11;
    @(posedge clk); #1;
    sw = 2'b00;
  endtask

  // framing, optional selection, four data words, DIP (R8)
  task automatic send_pass(input logic bad, input logic [1:0] selw, input int seed, input logic gaps);
    logic [1:0] a;
    logic [1:0] d;
    a = 2'b00;
    put(2'b11); if (gaps) idle();
    if (dual) begin a = step(a, selw); put(selw); if (gaps) idle(); end
    for (int i = 0; i < 4; i++) begin
      d = 2'((seed + i) % 3);
      a = step(a, d);
      put(d);
      if (gaps) idle();
    end
    d = ~step(a, 2'b11);
    if (bad) d = d ^ 2'b01;
    put(d);
  endtask

  task automatic drop(input logic exp_irq);
    port_en = 1'b0;
    @(posedge clk); #1;
    chk("R5 disable drops sync", sync_valid, 1'b0);
    chk("R6 irq on disable drop", irq, exp_irq);
    port_en = 1'b1;
    idle();
    chk("R6 irq one cycle", irq, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sync in reset", sync_valid, 1'b0);
    chk("R1 irq in reset", irq, 1'b0);
    rst_n = 1'b1;
    idle();
    chk("R1 sync after reset", sync_valid, 1'b0);

    // R2 sweep of good threshold, 0 acting as 1
    for (int g = 0; g <= 4; g++) begin
      int tgt;
      tgt = (g == 0) ? 1 : g;
      gth = 4'(g);
      for (int k = 1; k <= tgt; k++) begin
        send_pass(1'b0, 2'b01, g * 7 + k, 1'b0);
        chk("R2 good run", sync_valid, k == tgt);
        if (k == tgt) chk("R6 irq on rise", irq, 1'b1);
      end
      idle();
      chk("R6 irq cleared", irq, 1'b0);
      drop(1'b1);
    end

    // R2 a bad pass restarts the good run
    gth = 4'd3;
    send_pass(1'b0, 2'b01, 1, 1'b0); chk("R2 run 1", sync_valid, 1'b0);
    send_pass(1'b0, 2'b01, 2, 1'b0); chk("R2 run 2", sync_valid, 1'b0);
    send_pass(1'b1, 2'b01, 3, 1'b0); chk("R2 bad restarts", sync_valid, 1'b0);
    send_pass(1'b0, 2'b01, 4, 1'b0); chk("R2 rerun 1", sync_valid, 1'b0);
    send_pass(1'b0, 2'b01, 5, 1'b0); chk("R2 rerun 2", sync_valid, 1'b0);
    send_pass(1'b0, 2'b01, 6, 1'b0); chk("R2 rerun 3", sync_valid, 1'b1);

    // R3 sweep of bad threshold
    for (int b = 1; b <= 3; b++) begin
      bth = 4'(b);
      for (int k = 1; k <= b; k++) begin
        send_pass(1'b1, 2'b01, b + k, 1'b0);
        chk("R3 bad run", sync_valid, k < b);
        if (k == b) chk("R6 irq on fall", irq, 1'b1);
      end
      gth = 4'd1;
      send_pass(1'b0, 2'b01, b, 1'b0);
      chk("R3 regain", sync_valid, 1'b1);
    end

    // R3 a good pass restarts the bad run
    bth = 4'd2;
    send_pass(1'b1, 2'b01, 1, 1'b0); chk("R3 bad 1", sync_valid, 1'b1);
    send_pass(1'b0, 2'b01, 2, 1'b0); chk("R3 good restarts", sync_valid, 1'b1);
    send_pass(1'b1, 2'b01, 3, 1'b0); chk("R3 bad 1 again", sync_valid, 1'b1);
    send_pass(1'b1, 2'b01, 4, 1'b0); chk("R3 bad 2 drops", sync_valid, 1'b0);

    // R6 no pulse with irq disabled
    irq_en = 1'b0;
    gth = 4'd1;
    send_pass(1'b0, 2'b01, 5, 1'b0);
    chk("R6 masked rise sync", sync_valid, 1'b1);
    chk("R6 masked rise irq", irq, 1'b0);
    drop(1'b0);
    send_pass(1'b0, 2'b01, 6, 1'b0);
    irq_en = 1'b1;

    // R4 training run boundary
    bth = 4'd15;
    put(2'b00);
    for (int i = 1; i <= 11; i++) put(2'b11);
    chk("R4 eleven ones keep sync", sync_valid, 1'b1);
    put(2'b11);
    chk("R4 twelfth one drops", sync_valid, 1'b0);
    chk("R6 irq on training drop", irq, 1'b1);
    put(2'b00);
    send_pass(1'b0, 2'b01, 7, 1'b0);
    chk("R4 regain after training", sync_valid, 1'b1);

    // R5 passes ignored while port disabled
    port_en = 1'b0;
    send_pass(1'b0, 2'b01, 8, 1'b0);
    chk("R5 pass ignored while disabled", sync_valid, 1'b0);
    port_en = 1'b1;
    idle();

    // R8 idle gaps inside a pass
    gth = 4'd2;
    send_pass(1'b0, 2'b01, 9, 1'b1);  chk("R8 gapped pass 1", sync_valid, 1'b0);
    send_pass(1'b0, 2'b01, 10, 1'b1); chk("R8 gapped pass 2", sync_valid, 1'b1);
    drop(1'b1);

    // R7 calendar selection word
    dual = 1'b1; gth = 4'd1; bth = 4'd1;
    csel = 1'b1;
    send_pass(1'b0, 2'b10, 11, 1'b0); chk("R7 cal1 sel 10 good", sync_valid, 1'b1);
    send_pass(1'b0, 2'b01, 12, 1'b0); chk("R7 cal1 sel 01 bad", sync_valid, 1'b0);
    csel = 1'b0;
    send_pass(1'b0, 2'b01, 13, 1'b0); chk("R7 cal0 sel 01 good", sync_valid, 1'b1);
    send_pass(1'b0, 2'b10, 14, 1'b0); chk("R7 cal0 sel 10 bad", sync_valid, 1'b0);
    send_pass(1'b1, 2'b01, 15, 1'b0); chk("R8 bad parity right sel", sync_valid, 1'b0);
    send_pass(1'b0, 2'b00, 16, 1'b0); chk("R7 sel 00 bad", sync_valid, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule